// File: doc/BRIEF.md
# Serially Configured Lookup-Table Tile

This block is a small programmable logic tile. It contains four 3-input lookup tables and a 4x4 array of programmable crosspoints that join horizontal row wires to vertical column wires. Every table bit and every crosspoint bit sits in one 48-bit serial-in, parallel-out configuration chain. The chain takes one bit per clock from a single data pin, but only while the enable input is high. The far end of the chain appears on an output pin, so several tiles can be chained one after another.

After the chain is loaded, the tile acts as plain combinational logic. The first two tables read user inputs directly, and their outputs drive two of the row wires. The other two row wires come from pins. The crosspoints route row wires onto column wires, and the columns feed two inputs of each second-level table. Two tables that each compute half of a 4-input function can therefore be merged by a third table acting as a multiplexer.

Top module: `lut_tile`

## Requirements
- R1: While rst_n is low the whole chain clears to 0. After reset, lut_out, col_out and cfg_out are all 0 for every input value.
- R2: On each rising clock edge with cfg_en high, the chain moves one place toward its end and position 0 takes cfg_din. A 48-bit word shifted in most significant bit first lands with word bit i at chain position i. Table k bit j is position 8k+j. Crosspoint (row r, column c) is position 32+4r+c.
- R3: With cfg_en low the chain keeps its contents whatever cfg_din does. This is seen on lut_out, col_out and cfg_out.
- R4: A table's output equals its stored bit at index {in2,in1,in0}. For tables 0 and 1, inputs in0..in2 are lut_in bits 3k..3k+2 with in0 the lowest.
- R5: cfg_out always shows chain position 47. After 48 more enabled shifts, the previous contents appear on it in order, from position 47 down to position 0.
- R6: A column wire is the OR of every row wire whose crosspoint bit for that column is 1. A column with no crosspoint bit set reads 0.
- R7: Row 0 carries table 0's output and row 1 carries table 1's output. Rows 2 and 3 carry row_in bits 0 and 1.
- R8: Table 2 uses column 0 as in0, column 1 as in1 and lut_in bit 8 as in2. Table 3 uses columns 2 and 3 and lut_in bit 11. lut_in bits 6, 7, 9 and 10 have no effect. With suitable tables this yields any 4-input function on table 2.
- R9: lut_out and col_out follow lut_in and row_in within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset that clears the chain |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Chain end, for cascading tiles |
| lut_in | input | 12 | Table inputs, three bits per table (table k at bits 3k+2..3k) |
| row_in | input | 2 | External drivers of row wires 2 and 3 |
| lut_out | output | 4 | Table outputs, bit k from table k |
| col_out | output | 4 | Column wire values |

## Verification
A configuration bit takes effect at the first rising edge on which cfg_en is high. cfg_out moves one chain position on that same edge. The table and column outputs settle combinationally in the same cycle as their inputs. The bench therefore changes inputs just after a rising edge, queues the expected outputs at that moment, and a monitor compares them at the next falling edge. During a checked load, one expected item is queued for every shift, so the serial output is compared once per edge against a bench-side shadow of the chain.

// File: rtl/lut_tile_pkg.sv
package lut_tile_pkg;

   // Total configuration bits held by a tile of the given shape.
   function automatic int chain_bits(input int luts, input int k,
                                     input int rows, input int cols);
      return luts * (1 << k) + rows * cols;
   endfunction

endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
   parameter int LEN = 48
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shift_en,
   input  logic           din,
   output logic [LEN-1:0] q
);

   if (LEN < 2) begin : g_len_bad
      $error("cfg_chain needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (shift_en)
         q <= {q[LEN-2:0], din};
   end

   // R3
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(q));

   // R2
   cfg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> q[0] == $past(din));

endmodule

// File: rtl/lut_mux.sv
module lut_mux #(
   parameter int K = 3
) (
   input  logic [(1<<K)-1:0] table_bits,
   input  logic [K-1:0]      sel,
   output logic              y
);

   if (K < 1) begin : g_k_bad
      $error("lut_mux needs at least one select input");
   end

   assign y = table_bits[sel];

endmodule

// File: rtl/xbar_array.sv
module xbar_array #(
   parameter int ROWS = 4,
   parameter int COLS = 4
) (
   input  logic [ROWS*COLS-1:0] conn,
   input  logic [ROWS-1:0]      row_w,
   output logic [COLS-1:0]      col_w
);

   if (ROWS < 1 || COLS < 1) begin : g_dim_bad
      $error("xbar_array needs at least one row and one column");
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [ROWS-1:0] tap;
      logic [ROWS-1:0] sw;

      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign sw[r]  = conn[r*COLS + c];
         assign tap[r] = row_w[r] & sw[r];
      end

      assign col_w[c] = |tap;

      always_comb begin
         // R6
         if (sw == '0)
            col_float_chk: assert (col_w[c] == 1'b0);
         // R6
         if ((row_w & sw) != '0)
            col_connect_chk: assert (col_w[c] == 1'b1);
      end
   end

endmodule

// File: rtl/lut_tile.sv
module lut_tile #(
   parameter int NUM_LUTS    = 4,
   parameter int LUT_K       = 3,
   parameter int FIRST_LEVEL = 2,
   parameter int ROWS        = 4,
   parameter int COLS        = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_en,
   input  logic                          cfg_din,
   output logic                          cfg_out,
   input  logic [NUM_LUTS*LUT_K-1:0]     lut_in,
   input  logic [ROWS-FIRST_LEVEL-1:0]   row_in,
   output logic [NUM_LUTS-1:0]           lut_out,
   output logic [COLS-1:0]               col_out
);

   localparam int TBL       = 1 << LUT_K;
   localparam int LUT_BITS  = NUM_LUTS * TBL;
   localparam int XBAR_BITS = ROWS * COLS;
   localparam int CHAIN_LEN = lut_tile_pkg::chain_bits(NUM_LUTS, LUT_K, ROWS, COLS);
   localparam int SECOND    = NUM_LUTS - FIRST_LEVEL;

   if (LUT_K < 3) begin : g_k_bad
      $error("lut_tile needs tables of three or more inputs");
   end
   if (FIRST_LEVEL < 1 || SECOND < 1) begin : g_level_bad
      $error("lut_tile needs tables on both levels");
   end
   if (ROWS <= FIRST_LEVEL) begin : g_rows_bad
      $error("lut_tile needs at least one externally driven row");
   end
   if (COLS < 2 * SECOND) begin : g_cols_bad
      $error("lut_tile needs two columns per second-level table");
   end

   logic [CHAIN_LEN-1:0] chain_q;
   logic [ROWS-1:0]      row_w;
   logic [COLS-1:0]      col_w;
   logic [SECOND-1:0]    unused_low_sel;

   cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_en),
      .din      (cfg_din),
      .q        (chain_q)
   );

   assign cfg_out = chain_q[CHAIN_LEN-1];

   // First-level tables read pins; second-level tables read columns.
   for (genvar g = 0; g < NUM_LUTS; g++) begin : g_lut
      logic [LUT_K-1:0] sel;

      if (g < FIRST_LEVEL) begin : g_pin
         assign sel = lut_in[g*LUT_K +: LUT_K];
      end else begin : g_routed
         assign sel = {lut_in[g*LUT_K+2 +: LUT_K-2],
                       col_w[2*(g-FIRST_LEVEL)+1],
                       col_w[2*(g-FIRST_LEVEL)]};
         assign unused_low_sel[g-FIRST_LEVEL] = ^lut_in[g*LUT_K +: 2];
      end

      lut_mux #(.K(LUT_K)) u_lut (
         .table_bits (chain_q[g*TBL +: TBL]),
         .sel        (sel),
         .y          (lut_out[g])
      );
   end

   assign row_w = {row_in, lut_out[FIRST_LEVEL-1:0]};

   xbar_array #(.ROWS(ROWS), .COLS(COLS)) u_xbar (
      .conn  (chain_q[LUT_BITS +: XBAR_BITS]),
      .row_w (row_w),
      .col_w (col_w)
   );

   assign col_out = col_w;

   // R5
   cfg_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> cfg_out == $past(chain_q[CHAIN_LEN-2]));

endmodule

// File: tb/lut_tile_bench.sv
module lut_tile_bench;

   logic        clk = 1'b0;
   logic        rst_n, cfg_en, cfg_din;
   logic [11:0] lut_in;
   logic [1:0]  row_in;
   logic        cfg_out;
   logic [3:0]  lut_out, col_out;

   always #2 clk = ~clk;

   lut_tile u_lut_tile (
      .clk (clk), .rst_n (rst_n), .cfg_en (cfg_en), .cfg_din (cfg_din),
      .cfg_out (cfg_out), .lut_in (lut_in), .row_in (row_in),
      .lut_out (lut_out), .col_out (col_out)
   );

   typedef struct {
      logic [3:0] lo;
      logic [3:0] co;
      logic       so;
      string      tag;
   } exp_t;

   exp_t        sbq[$];
   int          checks = 0;
   int          errors = 0;
   logic [47:0] cfg_m;
   bit          finished = 0;

   // Expected outputs from the requirements, using the bench shadow of the chain.
   task automatic model(output logic [3:0] lo, output logic [3:0] co);
      logic [3:0] rows;
      lo[0] = cfg_m[0  + int'(lut_in[2:0])];
      lo[1] = cfg_m[8  + int'(lut_in[5:3])];
      rows  = {row_in, lo[1], lo[0]};
      for (int c = 0; c < 4; c++) begin
         co[c] = 1'b0;
         for (int r = 0; r < 4; r++)
            if (cfg_m[32 + 4*r + c] && rows[r]) co[c] = 1'b1;
      end
      lo[2] = cfg_m[16 + int'({lut_in[8],  co[1], co[0]})];
      lo[3] = cfg_m[24 + int'({lut_in[11], co[3], co[2]})];
   endtask

   task automatic push(input string tag);
      exp_t e;
      model(e.lo, e.co);
      e.so  = cfg_m[47];
      e.tag = tag;
      sbq.push_back(e);
   endtask

   // Monitor: compare queued expectations away from the active edge.
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         while (sbq.size() > 0) begin
            e = sbq.pop_front();
            checks++;
            if (lut_out !== e.lo || col_out !== e.co || cfg_out !== e.so) begin
               errors++;
               $display("FAIL %s: lut_out=%b col_out=%b cfg_out=%b expected %b %b %b",
                        e.tag, lut_out, col_out, cfg_out, e.lo, e.co, e.so);
            end
         end
      end
   end

   task automatic apply(input logic [11:0] li, input logic [1:0] ri, input string tag);
      @(posedge clk); #1;
      lut_in = li;
      row_in = ri;
      push(tag);
      @(negedge clk); #1;
   endtask

   task automatic load(input logic [47:0] v, input bit each, input string tag);
      @(posedge clk); #1;
      cfg_en  = 1'b1;
      cfg_din = v[47];
      for (int i = 47; i >= 0; i--) begin
         if (each) push(tag);
         @(negedge clk);
         @(posedge clk); #1;
         cfg_m = {cfg_m[46:0], v[i]};
         if (i > 0) cfg_din = v[i-1];
         else       cfg_en  = 1'b0;
      end
      push(tag);
      @(negedge clk); #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0;
      lut_in = '0; row_in = '0; cfg_m = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: cleared chain gives zero everywhere, even with inputs high
      apply(12'h000, 2'b00, "R1 reset");
      apply(12'hFFF, 2'b11, "R1 reset inputs high");

      // R2: AND3, XOR3, mux, majority; identity crosspoints, checked per shift
      load({16'h8421, 8'hE8, 8'hCA, 8'h96, 8'h80}, 1'b1, "R2 R5 shift");
      // R4 R7 R9: outputs follow inputs in the same cycle
      for (int i = 0; i < 16; i++) begin
         logic [3:0] n;
         n = 4'(i);
         apply({n[0], 2'b11, n[3], 2'b01, n[2:0] ^ 3'b101, n[2:0]}, n[1:0], "R4 R7 R9");
      end

      // R8: 4-input parity from two halves merged by table 2
      load({16'h0021, 8'h00, 8'hCA, 8'h69, 8'h96}, 1'b0, "R2 load parity");
      for (int i = 0; i < 16; i++) begin
         logic [3:0] n;
         n = 4'(i);
         apply({3'b000, n[3], ~n[1:0], n[2:0], n[2:0]}, 2'b00, "R8");
         checks++;
         if (lut_out[2] !== ^n) begin
            errors++;
            $display("FAIL R8 parity: lut_out[2]=%b expected %b", lut_out[2], ^n);
         end
      end

      // R6 R7: column 2 and column 1 unconnected, column 3 ORs rows 2 and 3
      load({16'h8900, 8'h00, 8'h00, 8'h00, 8'hFF}, 1'b0, "R2 load xbar");
      for (int i = 0; i < 4; i++)
         apply(12'h000, 2'(i), "R6 R7");

      // R3: data pin toggles with the enable low
      for (int i = 0; i < 20; i++) begin
         @(posedge clk); #1 cfg_din = ~cfg_din;
      end
      apply(12'h000, 2'b11, "R3 hold");
      checks++;
      if (col_out !== 4'b1001 || cfg_out !== 1'b1) begin
         errors++;
         $display("FAIL R3 hold: col_out=%b cfg_out=%b expected 1001 1", col_out, cfg_out);
      end

      // R5: previous contents stream out of the chain end in order
      load(48'h0, 1'b1, "R5 cascade");
      apply(12'hFFF, 2'b11, "R5 cleared");

      finish_run();
   end

endmodule